// File: doc/BRIEF.md
# Timestamp and Pulse Timer Unit

This block is the shared time base of a packet-processing engine. A 56-bit counter advances once for every reference-clock tick (nominally 19.2 MHz), presented to the block as a one-cycle strobe in the fast clock domain. Three coarse 32-bit timestamps are taken from that one counter. Each one starts at its own programmable bit position. A typical shift of 14 gives a tick of about 853 µs, and a shift of 24 gives a tick of about 874 ms. The log timestamp can instead show a legacy count of whole milliseconds.

A programmable divider turns the reference ticks into a common timer tick. With a field value of 191 the tick runs at 100 kHz. Three independent pulse generators count common ticks and emit a one-cycle strobe once per selected granularity. Downstream timers use these strobes. Software programs the block through a small write-only register port. The divider value can only be changed while the divider is disabled, so the intended sequence is: disable, load the value with the enable bit clear, then set the enable bit.

Top module: `tstamp_pulse_unit`

## Requirements
- R1: `ts_main` is a 56-bit counter. It rises by exactly one at every clock edge where `ref_tick` is high and keeps its value at every edge where `ref_tick` is low.
- R2: Register address 0 holds three shift fields: log shift in bits [5:0], tag shift in bits [13:8] and NAT shift in bits [21:16]. Each coarse output (`ts_log` when selected, `ts_tag`, `ts_nat`) equals bits [s+31:s] of `ts_main` for its shift s. Positions above bit 55 read as zero, so a shift of 56 or more gives zero.
- R3: Bit 24 of address 0 selects the source of `ts_log`: 1 selects the shifted counter, 0 selects the legacy millisecond count. The legacy count is the number of complete groups of REF_PER_MS reference ticks since reset.
- R4: Address 2 holds the divider value in bits [DIV_W-1:0] and the enable bit in bit 31. While enabled, `timer_tick` is a one-cycle strobe once every value+1 reference ticks.
- R5: A write to address 2 made while the divider is enabled leaves the divider value unchanged. Only its enable bit takes effect. A value written while the divider is disabled is loaded.
- R6: While the divider is disabled, `timer_tick` and all `pulse` bits stay low. On enable, the divider count restarts from zero, so the first `timer_tick` is high in the cycle after the (value+1)-th reference tick that follows the enabling write.
- R7: Address 1 holds one 2-bit granularity code per generator, for generator g in bits [4g+1:4g]. Codes 0, 1, 2 and 3 select GRAN_T0, GRAN_T1, GRAN_T2 and GRAN_T3 common ticks. The defaults are 1, 10, 100 and 1000 ticks, which is 10 µs, 100 µs, 1 ms and 10 ms at 100 kHz. Each `pulse[g]` is a one-cycle strobe once per that many common ticks.
- R8: The three generators run independently, each at its own granularity, from the same common tick.
- R9: A synchronous active-low reset clears the counter, the legacy count, every shift, the select bit, every granularity code and the divider value. It leaves the divider disabled with no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference-clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 timestamps, 1 granularities, 2 divider |
| wr_data | input | 32 | Register write data |
| ts_main | output | 56 | Free-running main timestamp |
| ts_log | output | 32 | Log timestamp, shifted or legacy millisecond count |
| ts_tag | output | 32 | Tag timestamp, shifted view |
| ts_nat | output | 32 | NAT timestamp, shifted view |
| timer_tick | output | 1 | Common timer tick strobe |
| pulse | output | 3 | Pulse generator strobes, one per generator |

## Verification
The bench builds the block with an 8-bit divider field, a legacy millisecond of 5 reference ticks, and granularity counts of 1, 2, 3 and 4 common ticks. These small values make every combination of divider values 0 to 4 and all four granularity codes on all three generators short enough to sweep exhaustively. Each measured pulse period is checked against (value+1) times the granularity count. The same small legacy period lets the legacy count be compared to the main counter divided by five at arbitrary moments. All 64 shift amounts are swept, including those past the top of the counter.

// File: rtl/tsp_pkg.sv
// Package tsp_pkg
// Shared constants and types for the timestamp and pulse timer unit.
// Assumes a 2-bit register address and 6-bit shift fields (shifts 0..63).
package tsp_pkg;

    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 32;
    localparam int SHIFT_W = 6;
    localparam int GRAN_W  = 2;

    localparam logic [ADDR_W-1:0] A_STAMP = 2'd0;
    localparam logic [ADDR_W-1:0] A_GRAN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV   = 2'd2;

    localparam int POS_TAG = 8;
    localparam int POS_NAT = 16;
    localparam int POS_SEL = 24;
    localparam int POS_EN  = 31;
    localparam int GRAN_STRIDE = 4;

    typedef struct packed {
        logic [SHIFT_W-1:0] sh_log;
        logic [SHIFT_W-1:0] sh_tag;
        logic [SHIFT_W-1:0] sh_nat;
        logic               log_sel;
    } stamp_cfg_t;

endpackage

// File: rtl/tsp_regs.sv
// Module tsp_regs
// Write-only configuration registers. Holds the shift fields, the log
// source select, the per-generator granularity codes and the divider.
// The divider value only loads while the divider is currently disabled.
// Assumes DIV_W <= 31 and N_GEN * 4 <= 32.
module tsp_regs
    import tsp_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int N_GEN = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output stamp_cfg_t                    stamp_cfg,
    output logic [N_GEN-1:0][GRAN_W-1:0]  gran,
    output logic [DIV_W-1:0]              div_val,
    output logic                          div_en
);

    // Register update on writes; divider value locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_cfg <= '0;
            gran      <= '0;
            div_val   <= '0;
            div_en    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_STAMP: begin
                    stamp_cfg.sh_log  <= wr_data[SHIFT_W-1:0];
                    stamp_cfg.sh_tag  <= wr_data[POS_TAG +: SHIFT_W];
                    stamp_cfg.sh_nat  <= wr_data[POS_NAT +: SHIFT_W];
                    stamp_cfg.log_sel <= wr_data[POS_SEL];
                end
                A_GRAN: begin
                    for (int g = 0; g < N_GEN; g++) begin
                        gran[g] <= wr_data[GRAN_STRIDE*g +: GRAN_W];
                    end
                end
                A_DIV: begin
                    div_en <= wr_data[POS_EN];
                    if (!div_en) begin
                        div_val <= wr_data[DIV_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: divider value never changes across an edge where it was enabled
    a_r5_value_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(div_en) |-> $stable(div_val));

endmodule

// File: rtl/tsp_stamp.sv
// Module tsp_stamp
// Main timestamp counter, the legacy millisecond counter and the three
// shifted 32-bit views. Assumes TS_W >= OUT_W and REF_PER_MS >= 1.
module tsp_stamp
    import tsp_pkg::*;
#(
    parameter int TS_W       = 56,
    parameter int OUT_W      = 32,
    parameter int REF_PER_MS = 19200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  stamp_cfg_t        cfg,
    output logic [TS_W-1:0]   ts_o,
    output logic [OUT_W-1:0]  log_o,
    output logic [OUT_W-1:0]  tag_o,
    output logic [OUT_W-1:0]  nat_o
);

    localparam int PRE_W = (REF_PER_MS > 1) ? $clog2(REF_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(REF_PER_MS - 1);

    logic [TS_W-1:0]  ts_q;
    logic [PRE_W-1:0] pre_q;
    logic [OUT_W-1:0] ms_q;

    // Shifted view: bits [s+OUT_W-1:s] with zero fill above the counter.
    function automatic logic [OUT_W-1:0] view(input logic [TS_W-1:0] t,
                                              input logic [SHIFT_W-1:0] s);
        logic [TS_W-1:0] sh;
        sh = t >> s;
        return sh[OUT_W-1:0];
    endfunction

    // Main counter: one step per reference tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (ref_tick) begin
            ts_q <= ts_q + 1'b1;
        end
    end

    // Legacy millisecond count: one step per REF_PER_MS reference ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (ref_tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign ts_o  = ts_q;
    assign log_o = cfg.log_sel ? view(ts_q, cfg.sh_log) : ms_q;
    assign tag_o = view(ts_q, cfg.sh_tag);
    assign nat_o = view(ts_q, cfg.sh_nat);

    // R1: counter advances by one on a reference tick
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> ts_q == TS_W'($past(ts_q) + 1'b1));
    // R1: counter holds without a reference tick
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(ts_q));

endmodule

// File: rtl/tsp_divider.sv
// Module tsp_divider
// Divides reference ticks by (value + 1) into a one-cycle common timer
// tick. The count is held at zero while disabled, so enabling restarts it.
module tsp_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             en_i,
    input  logic [DIV_W-1:0] val_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // Count reference ticks and strobe on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (!en_i) begin
                cnt_q <= '0;
            end else if (ref_tick) begin
                if (cnt_q >= val_i) begin
                    cnt_q  <= '0;
                    tick_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R6: no common tick follows a disabled cycle
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o);
    // R4: running count stays within the programmed value
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> cnt_q <= val_i);

endmodule

// File: rtl/tsp_pulse.sv
// Module tsp_pulse
// One pulse generator: counts common timer ticks and strobes once per
// selected granularity. Cleared while the divider is not running.
// Assumes every granularity count is at least 1.
module tsp_pulse
    import tsp_pkg::*;
#(
    parameter int GRAN_T0 = 1,
    parameter int GRAN_T1 = 10,
    parameter int GRAN_T2 = 100,
    parameter int GRAN_T3 = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [GRAN_W-1:0] gran_i,
    output logic              pulse_o
);

    localparam int M01   = (GRAN_T0 > GRAN_T1) ? GRAN_T0 : GRAN_T1;
    localparam int M23   = (GRAN_T2 > GRAN_T3) ? GRAN_T2 : GRAN_T3;
    localparam int TMAX  = (M01 > M23) ? M01 : M23;
    localparam int CNT_W = (TMAX > 1) ? $clog2(TMAX) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Last count value of the selected period.
    always_comb begin
        case (gran_i)
            2'd0:    last = CNT_W'(GRAN_T0 - 1);
            2'd1:    last = CNT_W'(GRAN_T1 - 1);
            2'd2:    last = CNT_W'(GRAN_T2 - 1);
            default: last = CNT_W'(GRAN_T3 - 1);
        endcase
    end

    // Count common ticks, wrap and strobe at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            if (!run_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q >= last) begin
                    cnt_q   <= '0;
                    pulse_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R7: every pulse is caused by a common tick one cycle earlier
    a_r7_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(tick_i));
    // R6: no pulse follows a cycle with the divider stopped
    a_r6_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pulse_o);

endmodule

// File: rtl/tstamp_pulse_unit.sv
// Module tstamp_pulse_unit
// Top of the time base: register port, main timestamp with shifted views,
// common timer divider and N_GEN pulse generators. Assumes ref_tick is a
// one-cycle strobe synchronous to clk.
module tstamp_pulse_unit
    import tsp_pkg::*;
#(
    parameter int TS_W       = 56,
    parameter int OUT_W      = 32,
    parameter int DIV_W      = 16,
    parameter int REF_PER_MS = 19200,
    parameter int N_GEN      = 3,
    parameter int GRAN_T0    = 1,
    parameter int GRAN_T1    = 10,
    parameter int GRAN_T2    = 100,
    parameter int GRAN_T3    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic [TS_W-1:0]   ts_main,
    output logic [OUT_W-1:0]  ts_log,
    output logic [OUT_W-1:0]  ts_tag,
    output logic [OUT_W-1:0]  ts_nat,
    output logic              timer_tick,
    output logic [N_GEN-1:0]  pulse
);

    stamp_cfg_t                   cfg;
    logic [N_GEN-1:0][GRAN_W-1:0] gran;
    logic [DIV_W-1:0]             div_val;
    logic                         div_en;

    tsp_regs #(.DIV_W(DIV_W), .N_GEN(N_GEN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .stamp_cfg (cfg),
        .gran      (gran),
        .div_val   (div_val),
        .div_en    (div_en)
    );

    tsp_stamp #(.TS_W(TS_W), .OUT_W(OUT_W), .REF_PER_MS(REF_PER_MS)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .cfg      (cfg),
        .ts_o     (ts_main),
        .log_o    (ts_log),
        .tag_o    (ts_tag),
        .nat_o    (ts_nat)
    );

    tsp_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .en_i     (div_en),
        .val_i    (div_val),
        .tick_o   (timer_tick)
    );

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        tsp_pulse #(
            .GRAN_T0 (GRAN_T0),
            .GRAN_T1 (GRAN_T1),
            .GRAN_T2 (GRAN_T2),
            .GRAN_T3 (GRAN_T3)
        ) u_pulse (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (div_en),
            .tick_i  (timer_tick),
            .gran_i  (gran[g]),
            .pulse_o (pulse[g])
        );
    end

endmodule

// File: tb/tstamp_pulse_unit_tb.sv
`timescale 1ns/1ps
// Bench for tstamp_pulse_unit with a small configuration: sweeps shifts,
// divider values and granularity codes; expected values are computed here.
module tstamp_pulse_unit_tb;

    localparam int DIV_W = 8;
    localparam int RPM   = 5;
    localparam int GT [4] = '{1, 2, 3, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [55:0] ts_main;
    logic [31:0] ts_log, ts_tag, ts_nat;
    logic        timer_tick;
    logic [2:0]  pulse;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    tstamp_pulse_unit #(
        .DIV_W(DIV_W), .REF_PER_MS(RPM),
        .GRAN_T0(GT[0]), .GRAN_T1(GT[1]), .GRAN_T2(GT[2]), .GRAN_T3(GT[3])
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ts_main(ts_main), .ts_log(ts_log), .ts_tag(ts_tag), .ts_nat(ts_nat),
        .timer_tick(timer_tick), .pulse(pulse)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic probe(input int sel);
        return (sel < 0) ? timer_tick : pulse[sel];
    endfunction

    // Waits for a strobe, then counts cycles to the next one.
    task automatic gap(input int sel, output int n);
        int w = 0;
        @(negedge clk);
        while (!probe(sel) && w < 5000) begin @(negedge clk); w++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!probe(sel) && n < 5000);
    endtask

    task automatic program_div(input int d);
        wr(2'd2, 32'd0);
        wr(2'd2, 32'(d));
        wr(2'd2, 32'h8000_0000 | 32'(d));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n, a, b, q;
        logic [55:0] sv;
        // R9: reset state
        repeat (5) @(negedge clk);
        chk("R9 ts_main", ts_main, 0);
        chk("R9 timer_tick", timer_tick, 0);
        chk("R9 pulse", pulse, 0);
        chk("R9 ts_log", ts_log, 0);
        @(negedge clk) rst_n = 1'b1;
        q = 0;
        repeat (20) begin @(negedge clk); q += timer_tick + pulse[0] + pulse[1] + pulse[2]; end
        chk("R9 divider disabled after reset", q, 0);

        // R1: counting with every-cycle and one-in-three reference ticks
        a = int'(ts_main);
        repeat (40) @(negedge clk);
        chk("R1 delta all ticks", ts_main - 56'(a), 40);
        a = int'(ts_main);
        for (int i = 0; i < 30; i++) begin ref_tick = (i % 3 == 0); @(negedge clk); end
        ref_tick = 1'b1;
        chk("R1 delta gated ticks", ts_main - 56'(a), 10);

        // R3: legacy source at reset
        for (int i = 0; i < 4; i++) begin
            repeat (3 + i) @(negedge clk);
            chk("R3 legacy count", ts_log, 32'(ts_main / RPM));
        end

        // R2: all shift amounts, log path selected
        for (int s = 0; s < 64; s++) begin
            wr(2'd0, 32'(s) | (32'((s + 7) % 64) << 8) | (32'(63 - s) << 16) | (32'd1 << 24));
            sv = ts_main;
            chk("R2 log view", ts_log, 32'(sv >> s));
            chk("R2 tag view", ts_tag, 32'(sv >> ((s + 7) % 64)));
            chk("R2 nat view", ts_nat, 32'(sv >> (63 - s)));
        end
        wr(2'd0, 32'd56 | (32'd60 << 8) | (32'd1 << 24));
        chk("R2 zero fill log", ts_log, 0);
        chk("R2 zero fill tag", ts_tag, 0);
        wr(2'd0, 32'd0);
        repeat (7) @(negedge clk);
        chk("R3 legacy after select cleared", ts_log, 32'(ts_main / RPM));

        // R4 and R7: divider values by granularity codes on every generator
        for (int d = 0; d < 5; d++) begin
            program_div(d);
            gap(-1, n);
            chk("R4 tick period", n, d + 1);
            for (int gr = 0; gr < 4; gr++) begin
                wr(2'd1, 32'(gr) | (32'(gr) << 4) | (32'(gr) << 8));
                for (int g = 0; g < 3; g++) begin
                    gap(g, n);
                    gap(g, n);
                    chk("R7 pulse period", n, (d + 1) * GT[gr]);
                end
            end
        end

        // R8: independent generators
        program_div(1);
        wr(2'd1, 32'd0 | (32'd2 << 4) | (32'd3 << 8));
        gap(0, n); gap(0, n); chk("R8 gen0", n, 2 * GT[0]);
        gap(1, n); gap(1, n); chk("R8 gen1", n, 2 * GT[2]);
        gap(2, n); gap(2, n); chk("R8 gen2", n, 2 * GT[3]);

        // R5: value written while enabled is ignored
        program_div(2);
        wr(2'd2, 32'h8000_0004);
        gap(-1, n); gap(-1, n);
        chk("R5 value locked while enabled", n, 3);

        // R6: quiet while disabled, restart on enable
        wr(2'd2, 32'd0);
        q = 0;
        repeat (40) begin @(negedge clk); q += timer_tick + pulse[0] + pulse[1] + pulse[2]; end
        chk("R6 quiet while disabled", q, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h8000_0003;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        while (!timer_tick && n < 100) begin @(negedge clk); n++; end
        chk("R6 first tick after enable", n, 5);
        gap(-1, n);
        chk("R5 value loaded while disabled", n, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule